// File: doc/BRIEF.md
# Quad DAC Command Register File

This block sits behind a serial front end that has already gathered a 24-bit command word. It keeps a double-buffered register pair for each of four converter channels. The first register is a staging (input) register. The second is the active register whose code drives the converter. Each channel also has a power state.

The upper byte of the word carries an operation and a channel selector. The lower 16 bits carry a left-justified code. The block supports these operations:

- stage a code;
- promote the staged code;
- stage and promote in one step;
- stage one channel and promote all four;
- power channels down.

Any promotion also wakes a sleeping channel. A per-channel counter then holds the ready indication low for a settling interval. The interval is longer when the whole device had been asleep.

Resolution is a parameter (16, 14 or 12 bits). A second parameter selects whether reset loads zero scale or midscale.

Top module: `quad_dac_regfile`

## Requirements
- R1: Bits 23:20 of the word are the operation, bits 19:16 the channel selector; the channel code is bits 15 down to 16-RES, and the remaining low bits have no effect.
- R2: Operation 0000 loads the staging register of the selected channel and leaves every active code unchanged.
- R3: Operation 0001 copies the staging register of the selected channel into its active register and powers that channel up.
- R4: Operation 0010 loads the staging register of the selected channel, then promotes and powers up all four channels.
- R5: Operation 0011 loads and promotes the selected channel in the same cycle.
- R6: Operation 0100 powers the selected channels down, clears their ready, and changes neither staging nor active codes.
- R7: Operation 1111, any unlisted operation, and any unlisted selector have no effect.
- R8: Selector values 0000 to 0011 pick channels 0 to 3; selector 1111 picks all four.
- R9: After reset all codes are zero (midscale when MID_RESET=1), and all channels are powered and ready.
- R10: A channel woken while at least one channel was still powered holds ready low and raises it exactly SHORT_WAKE cycles after the waking edge.
- R11: Channels woken while all four were powered down raise ready exactly LONG_WAKE cycles after the waking edge.
- R12: Promoting a channel that is already powered and ready leaves ready high.
- R13: With cmd_valid low the word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 24 | Operation, selector, code |
| active_code | output | 4*RES | Active codes, channel 0 in the low slice |
| ch_powered | output | 4 | Channel powered up |
| ch_ready | output | 4 | Channel powered and settled |

## Verification
The hardest condition to reach is the long wake interval. It needs every channel asleep at once, followed by a promotion, so the bench first issues a power-down to the all-channel selector. It then checks ready edge by edge against the long count. The short interval is reached by sleeping a single channel, and the staging contents surviving a sleep are shown by the code presented after the wake.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH = 4;

  typedef enum logic [3:0] {
    OP_STAGE     = 4'h0,
    OP_PROMOTE   = 4'h1,
    OP_STAGE_ALL = 4'h2,
    OP_STAGE_PRO = 4'h3,
    OP_SLEEP     = 4'h4,
    OP_IDLE      = 4'hF
  } op_e;

  typedef struct packed {
    logic [NCH-1:0] stage;
    logic [NCH-1:0] promote;
    logic [NCH-1:0] sleep;
  } ch_ctl_t;
endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
(
  input  logic        valid,
  input  logic [23:0] word,
  output ch_ctl_t     ctl
);
  logic [3:0]     op;
  logic [3:0]     sel_code;
  logic [NCH-1:0] sel;

  assign op       = word[23:20];
  assign sel_code = word[19:16];

  always_comb begin
    sel = '0;
    if (sel_code == 4'hF) sel = '1;
    else if (sel_code < NCH) sel[sel_code[1:0]] = 1'b1;
  end

  always_comb begin
    ctl = '0;
    if (valid && sel != '0) begin
      case (op)
        OP_STAGE:     ctl.stage   = sel;
        OP_PROMOTE:   ctl.promote = sel;
        OP_STAGE_ALL: begin ctl.stage = sel; ctl.promote = '1; end
        OP_STAGE_PRO: begin ctl.stage = sel; ctl.promote = sel; end
        OP_SLEEP:     ctl.sleep   = sel;
        default:      ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int RES        = 16,
  parameter int SHORT_WAKE = 5,
  parameter int LONG_WAKE  = 12,
  parameter bit MID_RESET  = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stage,
  input  logic           promote,
  input  logic           sleep,
  input  logic           all_asleep,
  input  logic [RES-1:0] new_code,
  output logic [RES-1:0] act_code,
  output logic           powered,
  output logic           ready
);
  localparam int MAXD = (SHORT_WAKE > LONG_WAKE) ? SHORT_WAKE : LONG_WAKE;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [RES-1:0] RST_CODE =
    MID_RESET ? {1'b1, {(RES-1){1'b0}}} : {RES{1'b0}};

  logic [RES-1:0] stage_q;
  logic [CW-1:0]  wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= RST_CODE;
      act_code <= RST_CODE;
      powered  <= 1'b1;
      ready    <= 1'b1;
      wait_q   <= '0;
    end else begin
      if (stage) stage_q <= new_code;
      if (promote) act_code <= stage ? new_code : stage_q;
      if (sleep) begin
        powered <= 1'b0;
        ready   <= 1'b0;
        wait_q  <= '0;
      end else if (promote && !powered) begin
        powered <= 1'b1;
        ready   <= 1'b0;
        wait_q  <= all_asleep ? CW'(LONG_WAKE) : CW'(SHORT_WAKE);
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
        ready  <= (wait_q == CW'(1));
      end
    end
  end
endmodule

// File: rtl/quad_dac_regfile.sv
module quad_dac_regfile
  import qdac_pkg::*;
#(
  parameter int RES        = 16,
  parameter int SHORT_WAKE = 5,
  parameter int LONG_WAKE  = 12,
  parameter bit MID_RESET  = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [23:0]        cmd_word,
  output logic [NCH*RES-1:0] active_code,
  output logic [NCH-1:0]     ch_powered,
  output logic [NCH-1:0]     ch_ready
);
  ch_ctl_t        ctl;
  logic [RES-1:0] code_in;
  logic           all_asleep;

  assign code_in    = cmd_word[15 -: RES];
  assign all_asleep = ~|ch_powered;

  qdac_decode u_dec (
    .valid (cmd_valid),
    .word  (cmd_word),
    .ctl   (ctl)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qdac_channel #(
      .RES        (RES),
      .SHORT_WAKE (SHORT_WAKE),
      .LONG_WAKE  (LONG_WAKE),
      .MID_RESET  (MID_RESET)
    ) u_ch (
      .clk        (clk),
      .rst        (rst),
      .stage      (ctl.stage[c]),
      .promote    (ctl.promote[c]),
      .sleep      (ctl.sleep[c]),
      .all_asleep (all_asleep),
      .new_code   (code_in),
      .act_code   (active_code[c*RES +: RES]),
      .powered    (ch_powered[c]),
      .ready      (ch_ready[c])
    );
  end
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int RES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [23:0]      cmd_word,
  input logic [4*RES-1:0] active_code,
  input logic [3:0]       ch_powered,
  input logic [3:0]       ch_ready
);
  logic sel_ok;
  assign sel_ok = (cmd_word[19:16] == 4'hF) || (cmd_word[19:16] < 4'd4);

  AST_STAGE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_word[23:20] == 4'h0 |=> $stable(active_code)); // R2

  AST_ALL_PROMOTE_POWERS: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_word[23:20] == 4'h2 && sel_ok |=> ch_powered == 4'hF); // R4

  AST_SLEEP_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_word[23:20] == 4'h4 |=> $stable(active_code)); // R6

  AST_SLEEP_ALL_DOWN: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_word[23:20] == 4'h4 && cmd_word[19:16] == 4'hF
    |=> ch_powered == 4'h0 && ch_ready == 4'h0); // R6

  AST_IDLE_OP_INERT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_word[23:20] == 4'hF
    |=> $stable(active_code) && $stable(ch_powered)); // R7

  AST_NO_VALID_INERT: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(active_code) && $stable(ch_powered)); // R13

  AST_READY_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
    (ch_ready & ~ch_powered) == 4'h0); // R10

  AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (ch_powered & ~$past(ch_powered) & ch_ready) == 4'h0); // R10
endmodule

bind quad_dac_regfile qdac_checker #(.RES(RES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_word    (cmd_word),
  .active_code (active_code),
  .ch_powered  (ch_powered),
  .ch_ready    (ch_ready)
);

// File: tb/quad_dac_regfile_tb.sv
module quad_dac_regfile_tb;
  localparam int RES   = 12;
  localparam int SHORT = 3;
  localparam int LONG  = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic [23:0]     cmd_word = '0;
  logic [4*RES-1:0] active_code;
  logic [3:0]      ch_powered;
  logic [3:0]      ch_ready;

  int checks = 0;
  int errors = 0;

  logic [RES-1:0] m_in  [4];
  logic [RES-1:0] m_act [4];
  logic [3:0]     m_pu;

  always #4 clk = ~clk;

  quad_dac_regfile #(
    .RES(RES), .SHORT_WAKE(SHORT), .LONG_WAKE(LONG), .MID_RESET(1'b0)
  ) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .active_code(active_code), .ch_powered(ch_powered), .ch_ready(ch_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [3:0] sel, input logic [15:0] data);
    logic [3:0] m;
    logic [RES-1:0] code;
    code = data[15 -: RES];
    m = (sel == 4'hF) ? 4'hF : (sel < 4) ? (4'b1 << sel) : 4'h0;
    if (m == 4'h0) return;
    for (int c = 0; c < 4; c++) begin
      case (op)
        4'h0: if (m[c]) m_in[c] = code;
        4'h1: if (m[c]) begin m_act[c] = m_in[c]; m_pu[c] = 1'b1; end
        4'h2: begin
          if (m[c]) m_in[c] = code;
          m_act[c] = m_in[c]; m_pu[c] = 1'b1;
        end
        4'h3: if (m[c]) begin m_in[c] = code; m_act[c] = code; m_pu[c] = 1'b1; end
        4'h4: if (m[c]) m_pu[c] = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [3:0] sel,
                      input logic [15:0] data, input bit vld = 1'b1);
    @(negedge clk);
    cmd_valid = vld;
    cmd_word  = {op, sel, data};
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
    if (vld) model(op, sel, data);
  endtask

  task automatic check_state(input string tag, input bit with_ready);
    for (int c = 0; c < 4; c++) begin
      chk($sformatf("%s code ch%0d", tag, c), 32'(active_code[c*RES +: RES]), 32'(m_act[c]));
      chk($sformatf("%s powered ch%0d", tag, c), 32'(ch_powered[c]), 32'(m_pu[c]));
      if (with_ready)
        chk($sformatf("%s ready ch%0d", tag, c), 32'(ch_ready[c]), 32'(m_pu[c]));
    end
  endtask

  task automatic wait_ready(input string tag, input int c, input int d);
    chk({tag, " ready low at wake"}, 32'(ch_ready[c]), 32'd0);
    for (int k = 1; k < d; k++) begin
      @(negedge clk);
      chk($sformatf("%s ready low cycle %0d", tag, k), 32'(ch_ready[c]), 32'd0);
    end
    @(negedge clk);
    chk({tag, " ready high at end"}, 32'(ch_ready[c]), 32'd1);
  endtask

  task automatic t_reset;
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_act[c] = '0; end
    m_pu = 4'hF;
    check_state("R9 reset", 1'b1);
  endtask

  task automatic t_stage_then_promote;
    send(4'h0, 4'h2, 16'hABC0);
    check_state("R2 stage only", 1'b1);
    send(4'h1, 4'h2, 16'h0000);
    chk("R3 R8 promote ch2", 32'(active_code[2*RES +: RES]), 32'h0ABC);
    check_state("R3 promote", 1'b1);
  endtask

  task automatic t_low_bits;
    send(4'h3, 4'h1, 16'h123F);
    chk("R1 R5 low bits ignored ch1", 32'(active_code[1*RES +: RES]), 32'h0123);
    check_state("R5 stage+promote", 1'b1);
  endtask

  task automatic t_stage_all;
    send(4'h0, 4'h0, 16'h5550);
    send(4'h2, 4'h3, 16'h7770);
    chk("R4 ch0 from staging", 32'(active_code[0 +: RES]), 32'h0555);
    chk("R4 ch3 new code", 32'(active_code[3*RES +: RES]), 32'h0777);
    check_state("R4 promote all", 1'b1);
  endtask

  task automatic t_short_wake;
    send(4'h4, 4'h1, 16'hFFF0);
    check_state("R6 sleep ch1", 1'b0);
    chk("R6 ready cleared", 32'(ch_ready[1]), 32'd0);
    send(4'h1, 4'h1, 16'h0000);
    chk("R6 staging kept ch1", 32'(active_code[1*RES +: RES]), 32'h0123);
    wait_ready("R10 short wake", 1, SHORT);
    check_state("R10 settled", 1'b1);
  endtask

  task automatic t_long_wake;
    send(4'h4, 4'hF, 16'h0000);
    check_state("R6 R8 sleep all", 1'b0);
    send(4'h1, 4'hF, 16'h0000);
    check_state("R11 woken", 1'b0);
    wait_ready("R11 long wake", 0, LONG);
    check_state("R11 settled", 1'b1);
  endtask

  task automatic t_ready_kept;
    send(4'h3, 4'h0, 16'h4440);
    chk("R12 ready stays", 32'(ch_ready[0]), 32'd1);
    check_state("R12 state", 1'b1);
  endtask

  task automatic t_reserved;
    send(4'h5, 4'h0, 16'h9990);
    send(4'hF, 4'hF, 16'h8880);
    send(4'h0, 4'h7, 16'h6660);
    send(4'h4, 4'h9, 16'h0000);
    check_state("R7 reserved and idle", 1'b1);
    send(4'h1, 4'hF, 16'h0000);
    check_state("R7 staging untouched", 1'b1);
  endtask

  task automatic t_no_valid;
    send(4'h3, 4'h2, 16'h1110, 1'b0);
    send(4'h4, 4'hF, 16'h0000, 1'b0);
    check_state("R13 valid low", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stage_then_promote();
    t_low_bits();
    t_stage_all();
    t_short_wake();
    t_long_wake();
    t_ready_kept();
    t_reserved();
    t_no_valid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule